// File: doc/BRIEF.md
# Power-Gate Release Sequencer

This block is a boot-time state machine that brings a graphics engine out of the power-gated state it is left in at power-on. After one start pulse it runs a fixed list of sixteen steps. Most steps change a single bit in one of three control registers. The first step holds the engine in reset and the later steps enable the block-level gating controllers, pulse the power-switch clamp with value 1, force the power-gate override off, pulse the clamp with value 0, release the gating controllers and take the engine out of reset. Two read-back steps order and flush the writes before them. Two settle waits of a programmable cycle count sit at fixed places in the list.

Every bit change is a read-modify-write, so no other bit of the target register changes. The block reads the register, merges the one bit into the data it read, and writes the merged word back. The register bus is a single request channel with valid/ready handshaking. The block raises `bus_valid` with address, direction and write data. The other side applies back-pressure by holding `bus_ready` low, and the block then keeps every request field stable. A transfer completes in the cycle in which both signals are high, and read data are taken in that same cycle. If a request gets no `bus_ready` within a timeout, the block sets a sticky error flag and returns to idle. A done pulse marks a completed sequence.

Top module: `pgr_release_seq`

## Requirements
- R1: While reset is applied and just after it is released, `bus_valid`, `done` and `error` are all 0.
- R2: A start pulse in idle runs these transfers in order. Register E is at 0x200, with the engine-run bit at 12 and the gating-control bit at 27. Register S is at 0x10A78C, with the clamp-mask bit at 0 and the clamp-value bit at 1. Register T is at 0x20004, with the override-enable bit at 30 and the override-value bit at 31 (0 = off). The steps are: E.12:=0; read E; E.27:=1; settle; S.1:=1; S.0:=1; S.0:=0; T.31:=0; T.30:=1; settle; S.1:=0; S.0:=1; S.0:=0; E.27:=0; E.12:=1; read E.
- R3: Each bit change is a read of the register followed at once by a write to the same address. The write data equal the data read, with only the target bit changed.
- R4: The two read-back steps are single reads with no write after them. Their data are discarded.
- R5: After the handshake of the write that sets E.27, and again after the handshake of the write that sets T.30, `bus_valid` stays low for exactly SETTLE_CYCLES cycles before the next request. Between all other transfers of a run, `bus_valid` does not drop.
- R6: While `bus_valid` is high and `bus_ready` is low, the request stays in place with `bus_addr`, `bus_we` and `bus_wdata` unchanged, unless the timeout of R9 ends it.
- R7: `done` is high for exactly one cycle, in the cycle after the handshake of the final read. `bus_valid` is low in that cycle and stays low afterwards.
- R8: A start pulse while a sequence runs is ignored. The run carries on unchanged and produces a single `done`.
- R9: A request that is held for TIMEOUT_CYCLES cycles without `bus_ready` sets `error`, and in that cycle `bus_valid` is already low and the block is idle. `bus_ready` arriving in the last of those cycles still completes the transfer without error.
- R10: `error` stays set while the block is idle and is cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches the sequence when idle |
| done | output | 1 | One-cycle pulse at sequence completion |
| error | output | 1 | Sticky flag set by a transfer timeout |
| bus_valid | output | 1 | Register request is valid |
| bus_ready | input | 1 | Responder accepts the request, completing it |
| bus_addr | output | ADDR_W | Register byte address |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wdata | output | 32 | Write data (merged word) |
| bus_rdata | input | 32 | Read data, sampled on the handshake cycle |

## Verification
The bench builds the block with SETTLE_CYCLES = 20 and TIMEOUT_CYCLES = 8. With these values both settle windows and the timeout window are short enough to count cycle by cycle on every run. It sweeps responder latencies 0 to 3 against four background patterns in the three modelled registers, so that each merged write is compared with a value computed from the bit rules. Running with a latency of 7 places the acknowledge on the last allowed cycle. A responder that never acknowledges drives the error path.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

  localparam int REG_W      = 32;
  localparam int STEP_COUNT = 16;
  localparam int STEP_IDX_W = $clog2(STEP_COUNT);
  localparam int BITPOS_W   = $clog2(REG_W);

  // Bit positions decoded by the target registers
  localparam int ENG_RUN_BIT    = 12;
  localparam int GATE_CTL_BIT   = 27;
  localparam int CLAMP_MASK_BIT = 0;
  localparam int CLAMP_VAL_BIT  = 1;
  localparam int OVR_EN_BIT     = 30;
  localparam int OVR_VAL_BIT    = 31;

  typedef enum logic [1:0] {
    OP_RMW    = 2'd0,
    OP_READ   = 2'd1,
    OP_SETTLE = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    REG_ENGINE  = 2'd0,
    REG_SWITCH  = 2'd1,
    REG_THERMAL = 2'd2
  } reg_sel_e;

  typedef struct packed {
    op_e                 op;
    reg_sel_e            sel;
    logic [BITPOS_W-1:0] pos;
    logic                val;
  } step_t;

  function automatic step_t mk_step(input op_e op, input reg_sel_e sel,
                                    input int pos, input logic val);
    step_t s;
    s.op  = op;
    s.sel = sel;
    s.pos = BITPOS_W'(pos);
    s.val = val;
    return s;
  endfunction

  // Ordered release sequence; the order is the behaviour
  function automatic step_t step_lookup(input logic [STEP_IDX_W-1:0] idx);
    case (idx)
      0:       return mk_step(OP_RMW,    REG_ENGINE,  ENG_RUN_BIT,    1'b0);
      1:       return mk_step(OP_READ,   REG_ENGINE,  0,              1'b0);
      2:       return mk_step(OP_RMW,    REG_ENGINE,  GATE_CTL_BIT,   1'b1);
      3:       return mk_step(OP_SETTLE, REG_ENGINE,  0,              1'b0);
      4:       return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_VAL_BIT,  1'b1);
      5:       return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_MASK_BIT, 1'b1);
      6:       return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_MASK_BIT, 1'b0);
      7:       return mk_step(OP_RMW,    REG_THERMAL, OVR_VAL_BIT,    1'b0);
      8:       return mk_step(OP_RMW,    REG_THERMAL, OVR_EN_BIT,     1'b1);
      9:       return mk_step(OP_SETTLE, REG_ENGINE,  0,              1'b0);
      10:      return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_VAL_BIT,  1'b0);
      11:      return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_MASK_BIT, 1'b1);
      12:      return mk_step(OP_RMW,    REG_SWITCH,  CLAMP_MASK_BIT, 1'b0);
      13:      return mk_step(OP_RMW,    REG_ENGINE,  GATE_CTL_BIT,   1'b0);
      14:      return mk_step(OP_RMW,    REG_ENGINE,  ENG_RUN_BIT,    1'b1);
      default: return mk_step(OP_READ,   REG_ENGINE,  0,              1'b0);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] merge_bit(input logic [REG_W-1:0] data,
                                                 input logic [BITPOS_W-1:0] pos,
                                                 input logic val);
    logic [REG_W-1:0] m;
    m = {{(REG_W-1){1'b0}}, 1'b1} << pos;
    return val ? (data | m) : (data & ~m);
  endfunction

endpackage

// File: rtl/pgr_step_rom.sv
module pgr_step_rom (
  input  logic [pgr_pkg::STEP_IDX_W-1:0] idx,
  output pgr_pkg::step_t                 step
);
  assign step = pgr_pkg::step_lookup(idx);
endmodule

// File: rtl/pgr_countdown.sv
module pgr_countdown #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgr_release_seq.sv
module pgr_release_seq #(
  parameter int              ADDR_W         = 24,
  parameter int              SETTLE_CYCLES  = 5_000_000,
  parameter int              TIMEOUT_CYCLES = 1024,
  parameter logic [ADDR_W-1:0] ENGINE_ADDR  = 24'h000200,
  parameter logic [ADDR_W-1:0] SWITCH_ADDR  = 24'h10A78C,
  parameter logic [ADDR_W-1:0] THERMAL_ADDR = 24'h020004
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       done,
  output logic                       error,
  output logic                       bus_valid,
  input  logic                       bus_ready,
  output logic [ADDR_W-1:0]          bus_addr,
  output logic                       bus_we,
  output logic [pgr_pkg::REG_W-1:0]  bus_wdata,
  input  logic [pgr_pkg::REG_W-1:0]  bus_rdata
);
  import pgr_pkg::*;

  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);
  localparam int TMO_W    = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [STEP_IDX_W-1:0] LAST_STEP = STEP_IDX_W'(STEP_COUNT - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_SETTLE} state_e;

  state_e                state_q, state_d;
  logic [STEP_IDX_W-1:0] step_q, step_d;
  step_t                 cur_q, nxt_step;
  logic [REG_W-1:0]      wdata_q;
  logic                  done_q, error_q;

  logic handshake, go, adv, rmw_rd, tmo_hit, last;
  logic settle_zero, tmo_zero;

  // Decode of the step that will be current next cycle
  pgr_step_rom u_rom (
    .idx  (step_d),
    .step (nxt_step)
  );

  pgr_countdown #(.WIDTH(SETTLE_W)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state_q != S_SETTLE),
    .load_val (SETTLE_W'(SETTLE_CYCLES - 1)),
    .dec      (state_q == S_SETTLE),
    .zero     (settle_zero)
  );

  pgr_countdown #(.WIDTH(TMO_W)) u_timeout (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (!bus_valid || handshake),
    .load_val (TMO_W'(TIMEOUT_CYCLES - 1)),
    .dec      (bus_valid && !bus_ready),
    .zero     (tmo_zero)
  );

  assign bus_valid = (state_q == S_READ) || (state_q == S_WRITE);
  assign bus_we    = (state_q == S_WRITE);
  assign bus_wdata = wdata_q;
  assign handshake = bus_valid && bus_ready;
  assign last      = (step_q == LAST_STEP);

  always_comb begin
    case (cur_q.sel)
      REG_ENGINE: bus_addr = ENGINE_ADDR;
      REG_SWITCH: bus_addr = SWITCH_ADDR;
      default:    bus_addr = THERMAL_ADDR;
    endcase
  end

  // Step progress, kept apart from the state choice that needs the decode
  always_comb begin
    go      = (state_q == S_IDLE) && start;
    rmw_rd  = (state_q == S_READ) && handshake && (cur_q.op == OP_RMW);
    tmo_hit = bus_valid && !bus_ready && tmo_zero;
    unique case (state_q)
      S_READ:   adv = handshake && (cur_q.op != OP_RMW);
      S_WRITE:  adv = handshake;
      S_SETTLE: adv = settle_zero;
      default:  adv = 1'b0;
    endcase
    if (go)              step_d = '0;
    else if (adv && !last) step_d = step_q + 1'b1;
    else                 step_d = step_q;
  end

  always_comb begin
    state_d = state_q;
    if (go) begin
      state_d = (nxt_step.op == OP_SETTLE) ? S_SETTLE : S_READ;
    end else if (rmw_rd) begin
      state_d = S_WRITE;
    end else if (adv) begin
      if (last) state_d = S_IDLE;
      else      state_d = (nxt_step.op == OP_SETTLE) ? S_SETTLE : S_READ;
    end else if (tmo_hit) begin
      state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      cur_q   <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cur_q   <= nxt_step;
      done_q  <= adv && last;
      if (rmw_rd)       wdata_q <= merge_bit(bus_rdata, cur_q.pos, cur_q.val);
      if (go)           error_q <= 1'b0;
      else if (tmo_hit) error_q <= 1'b1;
    end
  end

  assign done  = done_q;
  assign error = error_q;

endmodule

// File: rtl/pgr_release_seq_chk.sv
module pgr_release_seq_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic              error,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata
);
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_addr_q <= '0;
    else if (bus_valid && bus_ready && !bus_we) rd_addr_q <= bus_addr;
  end

  // R3
  rmw_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we) |-> (bus_addr == rd_addr_q));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> ($rose(error) ||
      (bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !bus_valid);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start) |=> error);

endmodule

bind pgr_release_seq pgr_release_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .error     (error),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_pgr_release_seq.sv
module tb_pgr_release_seq;
  localparam int ADDR_W = 24;
  localparam int SETTLE = 20;
  localparam int TMO    = 8;
  localparam int NTX    = 26;
  localparam logic [23:0] A_E = 24'h000200;
  localparam logic [23:0] A_S = 24'h10A78C;
  localparam logic [23:0] A_T = 24'h020004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        done, error, bus_valid, bus_we;
  logic        bus_ready = 1'b0;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  pgr_release_seq #(.ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Expected transfer list
  logic [23:0] e_addr [NTX];
  bit          e_we   [NTX];
  bit          e_plain[NTX];
  int          e_pos  [NTX];
  bit          e_val  [NTX];
  int          e_gap  [NTX];
  int          n_plan = 0;

  logic [31:0] mdl [4];
  int  lat = 0;
  bit  stall = 0;
  int  txn_idx = 0, gapcnt = 0, waitcnt = 0, done_cnt = 0, since_commit = 0;
  bit  fresh = 1;
  logic [23:0] hold_addr;
  logic        hold_we;
  logic [31:0] hold_wd;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic add_txn(input logic [23:0] a, input bit we, input bit plain,
                         input int pos, input bit v, input int gap);
    e_addr[n_plan] = a; e_we[n_plan] = we; e_plain[n_plan] = plain;
    e_pos[n_plan] = pos; e_val[n_plan] = v; e_gap[n_plan] = gap;
    n_plan++;
  endtask

  task automatic add_rmw(input logic [23:0] a, input int pos, input bit v, input int gap);
    add_txn(a, 1'b0, 1'b0, pos, v, gap);
    add_txn(a, 1'b1, 1'b0, pos, v, 0);
  endtask

  function automatic int ridx(input logic [23:0] a);
    if (a == A_E) return 0;
    if (a == A_S) return 1;
    if (a == A_T) return 2;
    return 3;
  endfunction

  task automatic commit();
    int k;
    logic [31:0] expv;
    int r;
    k = txn_idx;
    r = ridx(bus_addr);
    if (k >= NTX) begin
      chk(1'b0, "R2 transfer beyond end of sequence", k, NTX);
    end else begin
      chk(bus_addr == e_addr[k] && bus_we == e_we[k],
          e_plain[k] ? "R4 plain read-back order" : "R2 transfer order",
          {7'd0, bus_we, bus_addr}, {7'd0, e_we[k], e_addr[k]});
      chk(bus_addr == hold_addr && bus_we == hold_we && bus_wdata == hold_wd,
          "R6 request held under back-pressure", bus_addr, hold_addr);
      if (k > 0)
        chk(gapcnt == e_gap[k], e_gap[k] > 0 ? "R5 settle gap" : "R5 no gap", gapcnt, e_gap[k]);
      if (bus_we) begin
        expv = e_val[k] ? (mdl[r] | (32'd1 << e_pos[k])) : (mdl[r] & ~(32'd1 << e_pos[k]));
        chk(bus_wdata == expv, "R3 merged write data", bus_wdata, expv);
        mdl[r] = bus_wdata;
      end else begin
        bus_rdata = mdl[r];
      end
    end
    txn_idx++;
    gapcnt = 0;
    fresh = 1;
    since_commit = 0;
  endtask

  // Responder and monitor, sampling away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      since_commit++;
      if (done) begin
        done_cnt++;
        chk(since_commit == 1 && txn_idx == NTX, "R7 done timing", since_commit, 1);
      end
      if (bus_ready) begin
        bus_ready = 1'b0;
        waitcnt = 0;
      end
      if (bus_valid && fresh) begin
        hold_addr = bus_addr; hold_we = bus_we; hold_wd = bus_wdata; fresh = 0;
      end
      if (!bus_valid) gapcnt++;
      if (bus_valid && !stall) begin
        if (waitcnt < lat) waitcnt++;
        else begin
          bus_ready = 1'b1;
          commit();
        end
      end
    end
  end

  function automatic logic [31:0] pattern(input int p);
    case (p)
      0:       return 32'h0000_0000;
      1:       return 32'hFFFF_FFFF;
      2:       return 32'hA5A5_C33C;
      default: return 32'h5A5A_3CC3;
    endcase
  endfunction

  task automatic run_seq(input int lat_i, input logic [31:0] pat, input bit inject);
    logic [31:0] x0, x1, x2;
    lat = lat_i; stall = 0; waitcnt = 0;
    mdl[0] = pat; mdl[1] = pat ^ 32'h0F0F_33CC; mdl[2] = ~pat; mdl[3] = '0;
    txn_idx = 0; done_cnt = 0; fresh = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(error == 1'b0, "R10 error cleared by accepted start", error, 0);
    if (inject) begin
      wait (txn_idx == 5);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int g = 0; g < 3000; g++) begin
      @(negedge clk);
      if (done_cnt > 0) break;
    end
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, inject ? "R8 single done despite extra start" : "R7 one done pulse", done_cnt, 1);
    chk(txn_idx == NTX, inject ? "R8 transfer count unchanged" : "R2 transfer count", txn_idx, NTX);
    chk(bus_valid == 1'b0, "R7 bus quiet after done", bus_valid, 0);
    chk(error == 1'b0, "R9 no error on acknowledged run", error, 0);
    x0 = (pat | (32'd1 << 12)) & ~(32'd1 << 27);
    x1 = (pat ^ 32'h0F0F_33CC) & ~32'h3;
    x2 = (~pat | (32'd1 << 30)) & ~(32'd1 << 31);
    chk(mdl[0] == x0, "R2 final engine register", mdl[0], x0);
    chk(mdl[1] == x1, "R2 final switch register", mdl[1], x1);
    chk(mdl[2] == x2, "R2 final thermal register", mdl[2], x2);
  endtask

  task automatic run_timeout();
    int n;
    stall = 1; waitcnt = 0; n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (bus_valid && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == TMO, "R9 timeout window length", n, TMO);
    chk(error == 1'b1, "R9 error set on timeout", error, 1);
    repeat (5) @(negedge clk);
    chk(error == 1'b1 && bus_valid == 1'b0, "R10 error sticky while idle", error, 1);
    stall = 0;
  endtask

  initial begin
    add_rmw(A_E, 12, 1'b0, 0);
    add_txn(A_E, 1'b0, 1'b1, 0, 1'b0, 0);
    add_rmw(A_E, 27, 1'b1, 0);
    add_rmw(A_S, 1, 1'b1, SETTLE);
    add_rmw(A_S, 0, 1'b1, 0);
    add_rmw(A_S, 0, 1'b0, 0);
    add_rmw(A_T, 31, 1'b0, 0);
    add_rmw(A_T, 30, 1'b1, 0);
    add_rmw(A_S, 1, 1'b0, SETTLE);
    add_rmw(A_S, 0, 1'b1, 0);
    add_rmw(A_S, 0, 1'b0, 0);
    add_rmw(A_E, 27, 1'b0, 0);
    add_rmw(A_E, 12, 1'b1, 0);
    add_txn(A_E, 1'b0, 1'b1, 0, 1'b0, 0);

    repeat (3) @(negedge clk);
    chk(bus_valid == 0 && done == 0 && error == 0, "R1 idle in reset", {bus_valid, done, error}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_valid == 0 && done == 0 && error == 0, "R1 idle after reset", {bus_valid, done, error}, 0);

    for (int l = 0; l < 4; l++)
      for (int p = 0; p < 4; p++)
        run_seq(l, pattern(p), 1'b0);
    run_seq(2, pattern(2), 1'b1);
    run_timeout();
    run_seq(TMO - 1, pattern(3), 1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

endmodule